// File: doc/BRIEF.md
# Circular Request List Pointer Engine

This block keeps two fixed-size circular rings in internal storage: a request ring that the host fills and a device-side consumer drains, and a completion ring that a device-side producer fills and the host drains. Progress on each ring is published as the index of the newest filled slot rather than the next free one. Every pointer starts at the last slot after reset, so the first slot ever used is slot 0.

The host writes request slots (a 32-byte aligned address and a byte size) over a 32-bit register bus and then moves the request write pointer onto the newest slot it filled. The consumer sees a valid head entry whenever its private read index differs from that pointer, and pops entries strictly in ring order. Each completion pushed by the device stores its tag, ORed with a fixed host-marker mask, into the next completion slot. It then moves the shadow pointer onto that slot and latches an interrupt cause. The host compares the shadow with its own saved read index N and, while they differ, reads slot N+1, wrapping past the last slot. It writes its read index back so that the engine can refuse completions that would overrun unread slots.

Top module: `req_ring_engine`

## Requirements
- R1: After reset the request write pointer, the completion shadow pointer and the host read index all read DEPTH-1. cons_valid, cpl_full, irq and host_rdata are all 0.
- R2: Control registers sit at byte offsets 0x000 (request write pointer, read/write), 0x004 (completion shadow pointer, read-only), 0x008 (host read index, read/write), 0x00C (interrupt cause in bit 0) and 0x010 (interrupt enable in bit 0). A write of a value of DEPTH or more to 0x000 or 0x008 leaves that register unchanged.
- R3: Request slot k is stored at 0x800+8k, which holds the address, and 0x804+8k, which holds the size. Address bits 4:0 are dropped on write and read back as 0. All 32 size bits are kept.
- R4: cons_valid is 1 exactly while the consumer read index differs from the request write pointer. cons_idx, cons_addr and cons_size then present the slot after the read index. A pop advances the read index by one, and a pop while cons_valid is 0 changes nothing.
- R5: Every index steps from DEPTH-1 back to 0.
- R6: An accepted completion writes (tag OR HOST_MASK) into the slot after the shadow pointer, readable at 0xC00+4k. The shadow pointer becomes that slot's index on the next cycle.
- R7: cpl_full is 1 when the slot after the shadow pointer equals the host read index. A push while cpl_full is 1 changes no slot, pointer or cause.
- R8: An accepted completion sets the cause bit. Writing 1 to bit 0 of 0x00C clears it, and a push in the same cycle wins over the clear. irq equals cause AND enable.
- R9: host_rdata is loaded on the clock edge where host_rd is 1 and holds otherwise. Misaligned or unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| cons_valid | output | 1 | A request entry is waiting |
| cons_idx | output | PTR_W | Slot index of the head request |
| cons_addr | output | 32 | Head request address |
| cons_size | output | 32 | Head request size |
| cons_pop | input | 1 | Consumer takes the head entry |
| cpl_valid | input | 1 | Completion push strobe |
| cpl_tag | input | TAG_W | Request tag being completed |
| cpl_full | output | 1 | Completion ring cannot take a push |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after the off-by-one traps of a last-filled-slot convention. It checks that the first consumed slot after reset is 0, that the head moves from DEPTH-1 to 0, and that the completion ring holds exactly DEPTH-1 unread entries before it reports full. A design that treated the pointer as next-free would present the wrong slot or show one phantom entry. A full test off by one would either drop a completion the host never sees or stall one slot early. The bench also covers a cause clear that lands together with a push, where a design that lets the clear win would lose an interrupt. It covers pops on an empty ring and out-of-range pointer writes, which must leave the ring state untouched.

// File: rtl/req_ring_engine.sv
module req_ring_engine #(
  parameter int DEPTH = 32,
  parameter int TAG_W = 16,
  parameter logic [31:0] HOST_MASK = 32'hC000_0000,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [11:0]      host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             cons_valid,
  output logic [PTR_W-1:0] cons_idx,
  output logic [31:0]      cons_addr,
  output logic [31:0]      cons_size,
  input  logic             cons_pop,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic             cpl_full,
  output logic             irq
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] in_wp, cons_rp, ob_wp, host_ack;
  logic             cause, ien;
  logic [26:0]      ia_mem  [DEPTH];
  logic [31:0]      isz_mem [DEPTH];
  logic [31:0]      ob_mem  [DEPTH];
  logic [31:0]      rd_mux;

  wire        aligned  = host_addr[1:0] == 2'b00;
  wire        sel_ctl  = aligned && host_addr[11:10] == 2'b00;
  wire [7:0]  ctl_reg  = host_addr[9:2];
  wire [6:0]  in_slot  = host_addr[9:3];
  wire [7:0]  ob_slot  = host_addr[9:2];
  wire        in_hit   = aligned && host_addr[11:10] == 2'b10 && 32'(in_slot) < DEPTH;
  wire        ob_hit   = aligned && host_addr[11:10] == 2'b11 && 32'(ob_slot) < DEPTH;
  wire [PTR_W-1:0] in_idx = PTR_W'(in_slot);
  wire [PTR_W-1:0] ob_idx = PTR_W'(ob_slot);
  wire        wr_ctl   = host_wr && sel_ctl;
  wire        val_ok   = host_wdata < 32'(DEPTH);

  wire [PTR_W-1:0] cons_head = step(cons_rp);
  wire [PTR_W-1:0] ob_next   = step(ob_wp);
  wire             push_ok   = cpl_valid && !cpl_full;

  assign cons_valid = cons_rp != in_wp;
  assign cons_idx   = cons_head;
  assign cons_addr  = {ia_mem[cons_head], 5'b0};
  assign cons_size  = isz_mem[cons_head];
  assign cpl_full   = ob_next == host_ack;
  assign irq        = cause & ien;

  always_comb begin
    rd_mux = '0;
    if (sel_ctl) begin
      case (ctl_reg)
        8'd0:    rd_mux = 32'(in_wp);
        8'd1:    rd_mux = 32'(ob_wp);
        8'd2:    rd_mux = 32'(host_ack);
        8'd3:    rd_mux = {31'b0, cause};
        8'd4:    rd_mux = {31'b0, ien};
        default: rd_mux = '0;
      endcase
    end else if (in_hit) begin
      rd_mux = host_addr[2] ? isz_mem[in_idx] : {ia_mem[in_idx], 5'b0};
    end else if (ob_hit) begin
      rd_mux = ob_mem[ob_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp      <= LAST;
      cons_rp    <= LAST;
      ob_wp      <= LAST;
      host_ack   <= LAST;
      cause      <= 1'b0;
      ien        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (cons_pop && cons_valid) cons_rp <= cons_head;
      if (wr_ctl && ctl_reg == 8'd0 && val_ok) in_wp <= PTR_W'(host_wdata);
      if (wr_ctl && ctl_reg == 8'd2 && val_ok) host_ack <= PTR_W'(host_wdata);
      if (wr_ctl && ctl_reg == 8'd4) ien <= host_wdata[0];
      if (push_ok) begin
        ob_wp <= ob_next;
        cause <= 1'b1;
      end else if (wr_ctl && ctl_reg == 8'd3 && host_wdata[0]) begin
        cause <= 1'b0;
      end
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr && in_hit) begin
      if (host_addr[2]) isz_mem[in_idx] <= host_wdata;
      else              ia_mem[in_idx]  <= host_wdata[31:5];
    end
    if (push_ok) ob_mem[ob_next] <= 32'(cpl_tag) | HOST_MASK;
  end

  // R4
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_pop && !cons_valid |=> $stable(cons_rp));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_full |=> $stable(ob_wp));

  // R8
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_full |=> cause);

  // R6
  shadow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> ob_wp == (($past(ob_wp) == LAST) ? '0 : $past(ob_wp) + 1'b1));

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(in_wp) < DEPTH && 32'(cons_rp) < DEPTH && 32'(ob_wp) < DEPTH && 32'(host_ack) < DEPTH);

endmodule

// File: tb/req_ring_engine_tb_top.sv
module req_ring_engine_tb_top;
  localparam int D = 32;
  localparam logic [31:0] MASK = 32'hC000_0000;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, cons_pop = 0, cpl_valid = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [15:0] cpl_tag = 0;
  logic [31:0] host_rdata, cons_addr, cons_size;
  logic [4:0]  cons_idx;
  logic cons_valid, cpl_full, irq;

  always #10 clk = ~clk;

  req_ring_engine #(.DEPTH(D), .TAG_W(16), .HOST_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cons_valid(cons_valid), .cons_idx(cons_idx), .cons_addr(cons_addr),
    .cons_size(cons_size), .cons_pop(cons_pop), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .cpl_full(cpl_full), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;

  int m_in, m_cons, m_ob, m_ack;
  bit m_cause, m_en;
  logic [31:0] m_rdata;
  logic [31:0] m_ia [D];
  logic [31:0] m_sz [D];
  logic [31:0] m_obm [D];

  function automatic int inc(int p);
    return (p == D - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    int k;
    if (a[1:0] != 0) return 0;
    if (a[11:10] == 2'b00) begin
      case (a[9:0])
        10'h000: return 32'(m_in);
        10'h004: return 32'(m_ob);
        10'h008: return 32'(m_ack);
        10'h00C: return {31'b0, m_cause};
        10'h010: return {31'b0, m_en};
        default: return 0;
      endcase
    end
    if (a[11:10] == 2'b10) begin
      k = int'(a[9:3]);
      if (k >= D) return 0;
      return a[2] ? m_sz[k] : m_ia[k];
    end
    k = int'(a[9:2]);
    if (k >= D) return 0;
    return m_obm[k];
  endfunction

  task automatic cyc(logic w, logic r, logic [11:0] a, logic [31:0] d,
                     logic p, logic cv, logic [15:0] t);
    bit vld, full;
    int k;
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    cons_pop = p; cpl_valid = cv; cpl_tag = t;
    #1;
    vld  = m_cons != m_in;
    full = inc(m_ob) == m_ack;
    chk("R4 valid", {31'b0, cons_valid}, {31'b0, vld});
    if (vld) begin
      chk("R4 idx", 32'(cons_idx), 32'(inc(m_cons)));
      chk("R3 addr", cons_addr, m_ia[inc(m_cons)]);
      chk("R3 size", cons_size, m_sz[inc(m_cons)]);
    end
    chk("R7 full", {31'b0, cpl_full}, {31'b0, full});
    chk("R8 irq", {31'b0, irq}, {31'b0, m_cause & m_en});
    chk("R9 rdata", host_rdata, m_rdata);
    @(posedge clk);
    if (r) m_rdata = m_read(a);
    if (w && a[1:0] == 0) begin
      if (a[11:10] == 2'b00) begin
        if (a[9:0] == 10'h000 && d < D) m_in = int'(d);
        if (a[9:0] == 10'h008 && d < D) m_ack = int'(d);
        if (a[9:0] == 10'h010) m_en = d[0];
        if (a[9:0] == 10'h00C && d[0]) m_cause = 0;
      end else if (a[11:10] == 2'b10 && int'(a[9:3]) < D) begin
        k = int'(a[9:3]);
        if (a[2]) m_sz[k] = d; else m_ia[k] = {d[31:5], 5'b0};
      end
    end
    if (p && vld) m_cons = inc(m_cons);
    if (cv && !full) begin
      m_ob = inc(m_ob);
      m_obm[m_ob] = 32'(t) | MASK;
      m_cause = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();             cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
  task automatic pop();              cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic push(logic [15:0] t); cyc(0, 0, 0, 0, 0, 1, t); endtask
  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    cyc(0, 1, a, 0, 0, 0, 0);
    chk(req, host_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    m_in = D - 1; m_cons = D - 1; m_ob = D - 1; m_ack = D - 1;
    m_cause = 0; m_en = 0; m_rdata = 0;
    for (int i = 0; i < D; i++) begin m_ia[i] = 0; m_sz[i] = 0; m_obm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    idle();
    chk("R1 cons_valid", {31'b0, cons_valid}, 0);
    chk("R1 cpl_full", {31'b0, cpl_full}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd_chk("R1 wptr", 12'h000, 31);
    rd_chk("R1 shadow", 12'h004, 31);
    rd_chk("R1 ack", 12'h008, 31);

    // R3 slot storage with alignment drop
    for (int k = 0; k < 4; k++) begin
      wr(12'(12'h800 + 8 * k), 32'h1000_0000 + 32'(k) * 32'h100 + 32'h1F);
      wr(12'(12'h804 + 8 * k), 32'(64 * (k + 1)));
    end
    rd_chk("R3 addr1", 12'h808, 32'h1000_0100);
    rd_chk("R3 size2", 12'h814, 192);

    // R4 consume in order, first slot 0
    wr(12'h000, 3);
    chk("R4 first idx", 32'(cons_idx), 0);
    for (int k = 0; k < 4; k++) pop();
    chk("R4 drained", {31'b0, cons_valid}, 0);
    pop();
    wr(12'h820, 32'h2000_0000); wr(12'h824, 512); wr(12'h000, 4);
    chk("R4 no skip after empty pop", 32'(cons_idx), 4);
    pop();

    // R2 out-of-range pointer writes, R9 unmapped reads
    wr(12'h000, 40);
    rd_chk("R2 wptr kept", 12'h000, 4);
    wr(12'h008, 32);
    rd_chk("R2 ack kept", 12'h008, 31);
    rd_chk("R9 unmapped", 12'h014, 0);
    rd_chk("R9 misaligned", 12'h802, 0);

    // R6 completions, R8 interrupt
    wr(12'h010, 1);
    push(16'h0055);
    chk("R8 irq set", {31'b0, irq}, 1);
    rd_chk("R6 shadow0", 12'h004, 0);
    rd_chk("R6 slot0", 12'hC00, 32'hC000_0055);
    push(16'h0101); push(16'h0202);
    rd_chk("R6 shadow2", 12'h004, 2);
    rd_chk("R6 slot2", 12'hC08, 32'hC000_0202);
    wr(12'h00C, 1);
    chk("R8 w1c", {31'b0, irq}, 0);
    cyc(1, 0, 12'h00C, 1, 0, 1, 16'h0303);
    chk("R8 set beats clear", {31'b0, irq}, 1);
    wr(12'h00C, 1); wr(12'h010, 0);
    push(16'h0404);
    chk("R8 gated", {31'b0, irq}, 0);
    rd_chk("R8 cause", 12'h00C, 1);
    wr(12'h00C, 1);

    // R7 fill to full
    acc = 0;
    for (int i = 0; i < 40; i++) begin
      if (!cpl_full) acc++;
      push(16'(i));
    end
    chk("R7 accepted", 32'(acc), 26);
    wr(12'h00C, 1);
    push(16'hBEEF);
    rd_chk("R7 shadow held", 12'h004, 30);
    rd_chk("R7 no cause", 12'h00C, 0);
    wr(12'h008, 5);
    push(16'h0A0A);
    rd_chk("R5 shadow 31", 12'h004, 31);
    push(16'h0B0B);
    rd_chk("R5 shadow wraps", 12'h004, 0);
    rd_chk("R5 slot0 rewritten", 12'hC00, 32'hC000_0B0B);

    // R5 request ring wrap
    for (int k = 5; k < D + 2; k++) begin
      wr(12'(12'h800 + 8 * (k % D)), 32'h3000_0000 + 32'(k) * 32'h20);
      wr(12'(12'h804 + 8 * (k % D)), 32'(k));
    end
    wr(12'h000, 31);
    for (int k = 5; k < D; k++) pop();
    chk("R5 drained at top", {31'b0, cons_valid}, 0);
    wr(12'h000, 1);
    chk("R5 idx wraps", 32'(cons_idx), 0);
    pop(); pop();
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule